// File: doc/BRIEF.md
# Page access permission and fault encoder

This block decides what a single memory access may do once the page walk has produced a leaf entry. It takes the leaf's combined permission bits (user, writable, no-execute), whether the leaf is already dirty, the leaf's protection key, the paging mode flags, two key-rights registers, and the access description: user or supervisor, and load, store or fetch. From these it works out the read, write and execute rights to install, whether the access faults, and the page-fault error code.

When the access succeeds, the block also reports which status bits the walker must write back into the entry. The accessed bit is always needed. The dirty bit is needed only on a store. On a load or fetch to a clean page, write permission is withheld from the granted rights, so the first real store comes back through the walker and marks the page dirty. Walking the tables and the memory update are left to the surrounding logic. All results are registered and appear one cycle after a valid request.

Top module: `pgperm_top`

## Requirements
- R1: Outputs are registered. `out_valid` is high in the cycle after `in_valid` was high, and results hold until the next request. During reset, every output is zero.
- R2: When `rsvd_hit` is set, the access faults with error bit 3 (reserved). Bits 0 and 5 stay clear, and this check takes priority over every other check.
- R3: A user access (`is_user`=1) to a page whose user bit is clear is a protection fault, which sets error bit 0.
- R4: Read is granted unless `sap_on` is set and the page is a user page. In that case neither read nor write is granted.
- R5: Write is granted if the page is writable. It is also granted for a supervisor access when `wp_on` is clear.
- R6: Execute is granted only when the no-execute bit is clear. For a supervisor access with `smep_on` set, the page must also not be a user page.
- R7: The key-rights register is `ukey_rights` for user pages when `ukeys_on` is set. Otherwise it is `skey_rights`, used only when `skeys_on` is set. A selected value of zero, or a disabled selection, applies no key restriction.
- R8: For key k, bit 2k of the selected register removes read and write. Bit 2k+1 removes only write, and only for user accesses or when `wp_on` is set.
- R9: An access that the key restriction forbids faults with error bits 5 and 0 both set.
- R10: On any fault, bit 2 is set for user accesses and bit 1 is set for stores (`acc`=1). For fetches (`acc`=2), bit 4 is set only when `nxe_on` or `smep_on` is set. Loads are `acc`=0.
- R11: A successful store reports `set_acc` and `set_dirty`. A successful load or fetch reports only `set_acc`, and to a clean page (`leaf_dirty`=0) it has write removed from the granted rights.
- R12: An access whose needed right (read for a load, write for a store, execute for a fetch) is missing faults with error bit 0. On any fault, all rights and both status outputs are zero. Without a fault, the error code is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| leaf_user | input | 1 | Combined user bit of the leaf |
| leaf_write | input | 1 | Combined writable bit |
| leaf_nx | input | 1 | Combined no-execute bit |
| leaf_dirty | input | 1 | Leaf already dirty |
| rsvd_hit | input | 1 | Walker found a reserved bit set |
| pkey | input | KEY_W | Leaf protection key |
| is_user | input | 1 | Access made at user level |
| acc | input | 2 | 0 load, 1 store, 2 fetch |
| wp_on | input | 1 | Write-protect mode |
| nxe_on | input | 1 | No-execute enabled |
| smep_on | input | 1 | Supervisor execute prevention |
| sap_on | input | 1 | Supervisor access prevention for this access |
| ukeys_on | input | 1 | User-page keys enabled |
| skeys_on | input | 1 | Supervisor-page keys enabled |
| ukey_rights | input | KRR_W | User key-rights register |
| skey_rights | input | KRR_W | Supervisor key-rights register |
| out_valid | output | 1 | Result valid |
| rd_ok | output | 1 | Read granted |
| wr_ok | output | 1 | Write granted |
| ex_ok | output | 1 | Execute granted |
| fault | output | 1 | Access faults |
| err_code | output | 6 | Error code |
| set_acc | output | 1 | Set accessed bit |
| set_dirty | output | 1 | Set dirty bit |

## Verification
The assertions check, on every cycle, that the results follow a request by one cycle, that a fault clears all rights and status requests, and that the error code is empty without a fault. They also check that a key fault always carries the protection bit, that a reserved fault carries neither the protection bit nor the key bit, and that a dirty request only accompanies a granted write. The way read, write and execute rights arise from the page bits, the mode flags and the selected key register depends on the input combination. Clean-page write withholding and the fetch instruction bit likewise show only in the bench's directed scenarios, where each result is compared with an independent model.

// File: rtl/pgperm_pkg.sv
package pgperm_pkg;
   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FETCH = 2'd2
   } acc_e;

   localparam int ERR_W  = 6;
   localparam int E_PRES = 0;
   localparam int E_WR   = 1;
   localparam int E_USR  = 2;
   localparam int E_RSV  = 3;
   localparam int E_INS  = 4;
   localparam int E_KEY  = 5;

   typedef struct packed {
      logic r;
      logic w;
      logic x;
   } rights_t;
endpackage

// File: rtl/pgperm_rights.sv
module pgperm_rights
   import pgperm_pkg::*;
(
   input  logic    pg_user,
   input  logic    pg_write,
   input  logic    pg_nx,
   input  logic    is_user,
   input  logic    sap_on,
   input  logic    wp_on,
   input  logic    smep_on,
   output rights_t base,
   output logic    user_block
);
   logic rd_allow;

   always_comb begin
      user_block = is_user & ~pg_user;
      rd_allow   = ~(sap_on & pg_user);
      base.r     = rd_allow;
      base.w     = rd_allow & (pg_write | ~(is_user | wp_on));
      base.x     = ~pg_nx & (is_user | ~(smep_on & pg_user));
   end
endmodule

// File: rtl/pgperm_keychk.sv
module pgperm_keychk
   import pgperm_pkg::*;
#(
   parameter int KEY_W    = 4,
   parameter bit HAS_KEYS = 1'b1,
   localparam int KRR_W   = 2 * (1 << KEY_W)
) (
   input  logic             pg_user,
   input  logic             is_user,
   input  logic             wp_on,
   input  logic             ukeys_on,
   input  logic             skeys_on,
   input  logic [KEY_W-1:0] pkey,
   input  logic [KRR_W-1:0] ukey_rights,
   input  logic [KRR_W-1:0] skey_rights,
   output rights_t          kmask
);
   generate
      if (HAS_KEYS) begin : g_keys
         logic [KRR_W-1:0] sel;
         logic             ad, wd;
         always_comb begin
            if (pg_user) sel = ukeys_on ? ukey_rights : '0;
            else         sel = skeys_on ? skey_rights : '0;
            ad = sel[{pkey, 1'b0}];
            wd = sel[{pkey, 1'b1}];
            kmask = '{r: 1'b1, w: 1'b1, x: 1'b1};
            if (ad) begin
               kmask.r = 1'b0;
               kmask.w = 1'b0;
            end else if (wd && (is_user || wp_on)) begin
               kmask.w = 1'b0;
            end
         end
      end else begin : g_nokeys
         logic unused;
         always_comb begin
            unused = ^{pg_user, is_user, wp_on, ukeys_on, skeys_on, pkey,
                       ukey_rights, skey_rights};
            kmask  = '{r: 1'b1, w: 1'b1, x: 1'b1};
         end
      end
   endgenerate
endmodule

// File: rtl/pgperm_fault.sv
module pgperm_fault
   import pgperm_pkg::*;
(
   input  logic             rsvd_hit,
   input  logic             user_block,
   input  rights_t          base,
   input  rights_t          kmask,
   input  logic [1:0]       acc,
   input  logic             is_user,
   input  logic             nxe_on,
   input  logic             smep_on,
   input  logic             leaf_dirty,
   output rights_t          grant,
   output logic             fault,
   output logic [ERR_W-1:0] err,
   output logic             set_acc,
   output logic             set_dirty
);
   logic    is_store, is_fetch, key_need, prot_need;
   rights_t merged;

   always_comb begin
      is_store = (acc == ACC_STORE);
      is_fetch = (acc == ACC_FETCH);
      merged   = base & kmask;
      key_need  = is_store ? kmask.w  : (is_fetch ? kmask.x  : kmask.r);
      prot_need = is_store ? merged.w : (is_fetch ? merged.x : merged.r);

      err       = '0;
      fault     = 1'b1;
      grant     = '0;
      set_acc   = 1'b0;
      set_dirty = 1'b0;
      if (rsvd_hit) begin
         err[E_RSV] = 1'b1;
      end else if (user_block) begin
         err[E_PRES] = 1'b1;
      end else if (!key_need) begin
         err[E_PRES] = 1'b1;
         err[E_KEY]  = 1'b1;
      end else if (!prot_need) begin
         err[E_PRES] = 1'b1;
      end else begin
         fault     = 1'b0;
         grant     = merged;
         set_acc   = 1'b1;
         set_dirty = is_store;
         if (!is_store && !leaf_dirty) grant.w = 1'b0;
      end
      if (fault) begin
         err[E_USR] = is_user;
         err[E_WR]  = is_store;
         err[E_INS] = is_fetch & (nxe_on | smep_on);
      end
   end
endmodule

// File: rtl/pgperm_top.sv
module pgperm_top
   import pgperm_pkg::*;
#(
   parameter int KEY_W    = 4,
   parameter bit HAS_KEYS = 1'b1,
   localparam int KRR_W   = 2 * (1 << KEY_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             leaf_user,
   input  logic             leaf_write,
   input  logic             leaf_nx,
   input  logic             leaf_dirty,
   input  logic             rsvd_hit,
   input  logic [KEY_W-1:0] pkey,
   input  logic             is_user,
   input  logic [1:0]       acc,
   input  logic             wp_on,
   input  logic             nxe_on,
   input  logic             smep_on,
   input  logic             sap_on,
   input  logic             ukeys_on,
   input  logic             skeys_on,
   input  logic [KRR_W-1:0] ukey_rights,
   input  logic [KRR_W-1:0] skey_rights,
   output logic             out_valid,
   output logic             rd_ok,
   output logic             wr_ok,
   output logic             ex_ok,
   output logic             fault,
   output logic [ERR_W-1:0] err_code,
   output logic             set_acc,
   output logic             set_dirty
);
   if (KEY_W < 1 || KEY_W > 6) begin : g_bad_key_w
      $error("pgperm_top: KEY_W out of range");
   end

   rights_t          base, kmask, grant;
   logic             user_block, f_c, sa_c, sd_c;
   logic [ERR_W-1:0] err_c;

   pgperm_rights u_rights (
      .pg_user(leaf_user), .pg_write(leaf_write), .pg_nx(leaf_nx),
      .is_user(is_user), .sap_on(sap_on), .wp_on(wp_on), .smep_on(smep_on),
      .base(base), .user_block(user_block)
   );

   pgperm_keychk #(.KEY_W(KEY_W), .HAS_KEYS(HAS_KEYS)) u_key (
      .pg_user(leaf_user), .is_user(is_user), .wp_on(wp_on),
      .ukeys_on(ukeys_on), .skeys_on(skeys_on), .pkey(pkey),
      .ukey_rights(ukey_rights), .skey_rights(skey_rights), .kmask(kmask)
   );

   pgperm_fault u_fault (
      .rsvd_hit(rsvd_hit), .user_block(user_block), .base(base), .kmask(kmask),
      .acc(acc), .is_user(is_user), .nxe_on(nxe_on), .smep_on(smep_on),
      .leaf_dirty(leaf_dirty), .grant(grant), .fault(f_c), .err(err_c),
      .set_acc(sa_c), .set_dirty(sd_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         rd_ok     <= 1'b0;
         wr_ok     <= 1'b0;
         ex_ok     <= 1'b0;
         fault     <= 1'b0;
         err_code  <= '0;
         set_acc   <= 1'b0;
         set_dirty <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            rd_ok     <= grant.r;
            wr_ok     <= grant.w;
            ex_ok     <= grant.x;
            fault     <= f_c;
            err_code  <= err_c;
            set_acc   <= sa_c;
            set_dirty <= sd_c;
         end
      end
   end

   a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r12_fault_no_rights: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> !(rd_ok || wr_ok || ex_ok || set_acc || set_dirty));
   a_r12_clean_code: assert property (@(posedge clk) disable iff (!rst_n)
      !fault |-> err_code == '0);
   a_r9_key_has_pres: assert property (@(posedge clk) disable iff (!rst_n)
      err_code[E_KEY] |-> err_code[E_PRES]);
   a_r2_rsvd_alone: assert property (@(posedge clk) disable iff (!rst_n)
      err_code[E_RSV] |-> !err_code[E_PRES] && !err_code[E_KEY]);
   a_r11_dirty_store: assert property (@(posedge clk) disable iff (!rst_n)
      set_dirty |-> set_acc && wr_ok && !fault);
endmodule

// File: tb/test_pgperm_top.sv
module test_pgperm_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic        in_valid = 0, leaf_user = 0, leaf_write = 0, leaf_nx = 0;
   logic        leaf_dirty = 0, rsvd_hit = 0, is_user = 0;
   logic [3:0]  pkey = 0;
   logic [1:0]  acc = 0;
   logic        wp_on = 0, nxe_on = 0, smep_on = 0, sap_on = 0;
   logic        ukeys_on = 0, skeys_on = 0;
   logic [31:0] ukey_rights = 0, skey_rights = 0;
   logic        out_valid, rd_ok, wr_ok, ex_ok, fault, set_acc, set_dirty;
   logic [5:0]  err_code;

   pgperm_top i_pgperm_top (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .leaf_user(leaf_user),
      .leaf_write(leaf_write), .leaf_nx(leaf_nx), .leaf_dirty(leaf_dirty),
      .rsvd_hit(rsvd_hit), .pkey(pkey), .is_user(is_user), .acc(acc),
      .wp_on(wp_on), .nxe_on(nxe_on), .smep_on(smep_on), .sap_on(sap_on),
      .ukeys_on(ukeys_on), .skeys_on(skeys_on), .ukey_rights(ukey_rights),
      .skey_rights(skey_rights), .out_valid(out_valid), .rd_ok(rd_ok),
      .wr_ok(wr_ok), .ex_ok(ex_ok), .fault(fault), .err_code(err_code),
      .set_acc(set_acc), .set_dirty(set_dirty)
   );

   int checks = 0;
   int fails  = 0;
   logic [11:0] exp_q[$];
   string       tag_q[$];

   // expected vector: {rd, wr, ex, fault, err[5:0], set_acc, set_dirty}
   function automatic logic [11:0] model();
      logic r, w, x, f, kr, kw, kx, need_k, need;
      logic [5:0] e;
      logic [31:0] sel;
      r = !(sap_on && leaf_user);                              // R4
      w = r && (leaf_write || (!is_user && !wp_on));            // R5
      x = !leaf_nx && (is_user || !(smep_on && leaf_user));     // R6
      sel = leaf_user ? (ukeys_on ? ukey_rights : 0)
                      : (skeys_on ? skey_rights : 0);           // R7
      kr = 1; kw = 1; kx = 1;
      if (sel[2*pkey]) begin kr = 0; kw = 0; end                // R8
      else if (sel[2*pkey+1] && (is_user || wp_on)) kw = 0;
      need_k = (acc == 1) ? kw : (acc == 2) ? kx : kr;
      r = r & kr; w = w & kw; x = x & kx;
      need = (acc == 1) ? w : (acc == 2) ? x : r;
      e = 0; f = 1;
      if (rsvd_hit) e[3] = 1;                                   // R2
      else if (is_user && !leaf_user) e[0] = 1;                 // R3
      else if (!need_k) begin e[0] = 1; e[5] = 1; end           // R9
      else if (!need) e[0] = 1;                                 // R12
      else f = 0;
      if (f) begin                                              // R10
         e[2] = is_user;
         e[1] = (acc == 1);
         e[4] = (acc == 2) && (nxe_on || smep_on);
         return {3'b000, 1'b1, e, 2'b00};
      end
      if (acc != 1 && !leaf_dirty) w = 0;                       // R11
      return {r, w, x, 1'b0, 6'd0, 1'b1, acc == 1};
   endfunction

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   task automatic send(input string tag);
      @(negedge clk);
      in_valid = 1;
      exp_q.push_back(model());
      tag_q.push_back(tag);
      @(negedge clk);
      in_valid = 0;
   endtask

   task automatic clear_all();
      leaf_user = 0; leaf_write = 0; leaf_nx = 0; leaf_dirty = 0; rsvd_hit = 0;
      is_user = 0; pkey = 0; acc = 0; wp_on = 0; nxe_on = 0; smep_on = 0;
      sap_on = 0; ukeys_on = 0; skeys_on = 0; ukey_rights = 0; skey_rights = 0;
   endtask

   // monitor
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && out_valid) begin
            logic [11:0] got, exp;
            string t;
            got = {rd_ok, wr_ok, ex_ok, fault, err_code, set_acc, set_dirty};
            checks++;
            if (exp_q.size() == 0) begin
               fails++;
               $display("FAIL R1: unexpected result got=%b expected=none", got);
            end else begin
               exp = exp_q.pop_front();
               t = tag_q.pop_front();
               if (got !== exp) begin
                  fails++;
                  $display("FAIL %s: got=%b expected=%b", t, got, exp);
               end
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if ({out_valid, rd_ok, wr_ok, ex_ok, fault, err_code, set_acc, set_dirty} !== 0) begin
         fails++;
         $display("FAIL R1: reset got=%b expected=0",
                  {out_valid, rd_ok, wr_ok, ex_ok, fault, err_code, set_acc, set_dirty});
      end
      rst_n = 1;

      // R11: supervisor load on writable clean page -> write withheld
      clear_all(); leaf_write = 1; send("R11 clean load");
      leaf_dirty = 1; send("R11 dirty load");
      acc = 1; send("R11 store sets dirty");
      // R2 reserved priority
      clear_all(); rsvd_hit = 1; is_user = 1; acc = 1; send("R2 rsvd");
      // R3 user to supervisor page
      clear_all(); is_user = 1; acc = 0; send("R3 user blocked");
      // R5 supervisor store read-only page, wp off then on
      clear_all(); leaf_dirty = 1; acc = 1; send("R5 wp off");
      wp_on = 1; send("R5 wp on");
      // R4 access prevention on user page
      clear_all(); leaf_user = 1; leaf_write = 1; leaf_dirty = 1; sap_on = 1;
      send("R4 sap load");
      // R6 exec rules
      clear_all(); acc = 2; leaf_nx = 1; nxe_on = 1; send("R6 nx fetch R10");
      clear_all(); acc = 2; leaf_user = 1; smep_on = 1; send("R6 smep fetch");
      is_user = 1; send("R6 user fetch");
      // R7/R8/R9 keys
      clear_all(); leaf_user = 1; is_user = 1; leaf_write = 1; leaf_dirty = 1;
      pkey = 4'd3; ukey_rights = 32'h40; ukeys_on = 1; send("R8 R9 key ad load");
      ukeys_on = 0; send("R7 user keys off");
      ukeys_on = 1; ukey_rights = 32'h80; acc = 1; send("R8 R9 key wd store");
      acc = 0; send("R8 key wd load");
      pkey = 4'd15; ukey_rights = 32'h4000_0000; send("R8 top key ad");
      clear_all(); leaf_write = 1; leaf_dirty = 1; acc = 1; pkey = 4'd2;
      skey_rights = 32'h20; skeys_on = 1; send("R8 sup wd wp off");
      wp_on = 1; send("R9 sup wd wp on");
      ukeys_on = 1; ukey_rights = 32'hFFFF_FFFF; skey_rights = 0; wp_on = 0;
      send("R7 zero sel no key");
      // R10 fetch without nxe/smep
      clear_all(); acc = 2; leaf_nx = 1; send("R10 fetch no I");
      // R12 user store to read-only
      clear_all(); is_user = 1; leaf_user = 1; acc = 1; send("R12 user ro store");
      // back-to-back
      clear_all(); leaf_write = 1;
      @(negedge clk); in_valid = 1; exp_q.push_back(model()); tag_q.push_back("R1 b2b a");
      @(negedge clk); acc = 1; exp_q.push_back(model()); tag_q.push_back("R1 b2b b");
      @(negedge clk); in_valid = 0;
      repeat (4) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL R1: pending got=%0d expected=0", exp_q.size());
      end
      finish_run();
   end
endmodule